// File: doc/BRIEF.md
# Infrared Run-Length Symbol Transmitter

This block is the transmit side of an infrared remote-control port. The host pushes 8-bit symbols into a 32-entry first-in first-out store. Each symbol is either a mark (pulse) or a gap (space), and gives a run length counted in sample periods. A player pulls the symbols out one at a time and holds the infrared line for each symbol's full duration. During a mark the line follows an externally generated carrier enable. During a gap, or when there is nothing left to play, the line stays low.

One sample period is `SAMPLE_CLKS` clock cycles scaled by a baud divisor input. A symbol lasts its run length times that period. The host paces its writes with the occupancy count and with a low-level interrupt. That interrupt asserts when occupancy is at or below one of four fixed levels, provided both its own enable and a global interrupt enable are set. A clear input discards everything that is queued or playing. A sticky flag records any write that was lost because the store was full.

Top module: `irtx_runlength`

## Requirements
- R1: The store keeps up to 32 symbols in write order. `fill_count` reports the number of stored symbols, not counting the one being played. A symbol is taken from the store on the clock edge after which the player is free, so a write into an empty idle block starts playing on the next edge.
- R2: Bit 7 of a symbol selects its kind: 0 is a mark, during which `ir_out` equals `carrier_on`; 1 is a space, during which `ir_out` is 0.
- R3: A symbol lasts L x SAMPLE_CLKS x D clock cycles, where L is bits 6:0 and D is `baud_div`, with a divisor of 0 treated as 1. A write arriving while a symbol plays never shortens it.
- R4: A run-length field of 0 counts as 128 sample periods.
- R5: Symbols play back to back with no idle cycle between them. `ir_out` is 0 whenever no symbol is playing.
- R6: A write while `fill_count` is 32 is dropped, even if a symbol leaves the store in the same cycle. It sets `overflow`, which stays set until reset or clear.
- R7: `fifo_clr` empties the store, stops the playing symbol and clears `overflow`. A write in the same cycle is dropped.
- R8: `thr_sel` encodes the low level: 0 gives 1, 1 gives 7, 2 gives 17, 3 gives 25.
- R9: `low_irq` is 1 exactly when `lowirq_en` and `irq_global_en` are both 1 and `fill_count` is at or below the selected level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Push one symbol this cycle |
| wr_data | input | 8 | Symbol: bit 7 kind, bits 6:0 run length |
| fifo_clr | input | 1 | Discard stored and playing symbols, clear overflow |
| thr_sel | input | 2 | Low-level select |
| lowirq_en | input | 1 | Low-level interrupt enable |
| irq_global_en | input | 1 | Global interrupt enable |
| baud_div | input | DIV_W | Sample-period divisor (0 acts as 1) |
| carrier_on | input | 1 | Carrier enable gated onto marks |
| ir_out | output | 1 | Infrared line |
| fill_count | output | CNT_W | Stored symbol count |
| overflow | output | 1 | Sticky lost-write flag |
| low_irq | output | 1 | Low-level interrupt |

## Verification
The bench goes after four corner cases.

- A zero run length: a design that decoded it literally would emit a zero- or one-period symbol instead of 128 periods.
- Writes against a full store: a design that wrapped its pointer would corrupt queued symbols or report a count of zero instead of raising overflow.
- Transitions between symbols: an extra idle cycle there, or a cut-short symbol after a late write, shows up as a cycle-exact mismatch of `ir_out` against a cycle-counting model.
- The four interrupt levels and the divisor value 0: each is swept, so a wrong level table or a divide-by-zero stall is exposed.

// File: rtl/irtx_pkg.sv
package irtx_pkg;

    localparam int SYM_W  = 8;
    localparam int LEN_W  = 7;
    localparam int RUN_W  = LEN_W + 1;

    typedef enum logic {
        PL_IDLE = 1'b0,
        PL_RUN  = 1'b1
    } play_state_t;

    typedef struct packed {
        logic              is_space;
        logic [LEN_W-1:0]  len;
    } ir_sym_t;

    // run-length field to period count; zero stands for the longest run
    function automatic logic [RUN_W-1:0] run_periods(input logic [LEN_W-1:0] f);
        if (f == '0) return RUN_W'(1 << LEN_W);
        return RUN_W'(f);
    endfunction

    // low-level interrupt thresholds, deliberately non-linear
    function automatic logic [7:0] thr_level(input logic [1:0] sel);
        case (sel)
            2'd0:    return 8'd1;
            2'd1:    return 8'd7;
            2'd2:    return 8'd17;
            default: return 8'd25;
        endcase
    endfunction

endpackage

// File: rtl/irtx_fifo.sv
module irtx_fifo
    import irtx_pkg::*;
#(
    parameter int DEPTH = 32,
    parameter int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             push,
    input  ir_sym_t          din,
    input  logic             pop,
    output ir_sym_t          dout,
    output logic [CNT_W-1:0] count,
    output logic             empty,
    output logic             ovf
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    ir_sym_t          mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic             full, do_push, do_pop;

    function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
        if (p == PTR_W'(DEPTH - 1)) return '0;
        return p + PTR_W'(1);
    endfunction

    assign full    = (count == CNT_W'(DEPTH));
    assign empty   = (count == '0);
    assign do_push = push && !clr && !full;
    assign do_pop  = pop && !clr && !empty;
    assign dout    = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= din;
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= ptr_inc(wr_ptr);
            if (do_pop)  rd_ptr <= ptr_inc(rd_ptr);
            case ({do_push, do_pop})
                2'b10:   count <= count + CNT_W'(1);
                2'b01:   count <= count - CNT_W'(1);
                default: count <= count;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst || clr)              ovf <= 1'b0;
        else if (push && full)       ovf <= 1'b1;
    end

endmodule

// File: rtl/irtx_player.sv
module irtx_player
    import irtx_pkg::*;
#(
    parameter int SAMPLE_CLKS = 4,
    parameter int DIV_W       = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             abort,
    input  logic             sym_valid,
    input  ir_sym_t          sym,
    input  logic [DIV_W-1:0] baud_div,
    input  logic             carrier_on,
    output logic             pop,
    output logic             ir_out
);
    localparam int UNIT_W = DIV_W + $clog2(SAMPLE_CLKS + 1);

    play_state_t       state;
    logic [RUN_W-1:0]  runs_left;
    logic [UNIT_W-1:0] tick, unit_lim;
    logic [DIV_W-1:0]  eff_div;
    logic              cur_space, tick_end, last_tick;

    assign eff_div   = (baud_div == '0) ? DIV_W'(1) : baud_div;
    assign unit_lim  = UNIT_W'(SAMPLE_CLKS) * UNIT_W'(eff_div) - UNIT_W'(1);
    assign tick_end  = (tick == unit_lim);
    assign last_tick = (state == PL_RUN) && tick_end && (runs_left == RUN_W'(1));
    assign pop       = !abort && sym_valid && ((state == PL_IDLE) || last_tick);
    assign ir_out    = (state == PL_RUN) && !cur_space && carrier_on;

    always_ff @(posedge clk) begin
        if (rst || abort) begin
            state     <= PL_IDLE;
            tick      <= '0;
            runs_left <= '0;
            cur_space <= 1'b1;
        end else if (pop) begin
            state     <= PL_RUN;
            tick      <= '0;
            runs_left <= run_periods(sym.len);
            cur_space <= sym.is_space;
        end else if (state == PL_RUN) begin
            if (tick_end) begin
                tick <= '0;
                if (runs_left == RUN_W'(1)) state <= PL_IDLE;
                else                         runs_left <= runs_left - RUN_W'(1);
            end else begin
                tick <= tick + UNIT_W'(1);
            end
        end
    end

endmodule

// File: rtl/irtx_lowirq.sv
module irtx_lowirq
    import irtx_pkg::*;
#(
    parameter int CNT_W = 6
) (
    input  logic [CNT_W-1:0] count,
    input  logic [1:0]       thr_sel,
    input  logic             lowirq_en,
    input  logic             irq_global_en,
    output logic             low_irq
);
    logic below;
    assign below   = (int'(count) <= int'(thr_level(thr_sel)));
    assign low_irq = lowirq_en && irq_global_en && below;
endmodule

// File: rtl/irtx_runlength.sv
module irtx_runlength
    import irtx_pkg::*;
#(
    parameter int DEPTH       = 32,
    parameter int SAMPLE_CLKS = 4,
    parameter int DIV_W       = 8,
    parameter int CNT_W       = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [SYM_W-1:0] wr_data,
    input  logic             fifo_clr,
    input  logic [1:0]       thr_sel,
    input  logic             lowirq_en,
    input  logic             irq_global_en,
    input  logic [DIV_W-1:0] baud_div,
    input  logic             carrier_on,
    output logic             ir_out,
    output logic [CNT_W-1:0] fill_count,
    output logic             overflow,
    output logic             low_irq
);
    ir_sym_t head, wsym;
    logic    empty, pop;

    assign wsym = ir_sym_t'(wr_data);

    irtx_fifo #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_fifo (
        .clk   (clk),
        .rst   (rst),
        .clr   (fifo_clr),
        .push  (wr_en),
        .din   (wsym),
        .pop   (pop),
        .dout  (head),
        .count (fill_count),
        .empty (empty),
        .ovf   (overflow)
    );

    irtx_player #(.SAMPLE_CLKS(SAMPLE_CLKS), .DIV_W(DIV_W)) u_player (
        .clk        (clk),
        .rst        (rst),
        .abort      (fifo_clr),
        .sym_valid  (!empty),
        .sym        (head),
        .baud_div   (baud_div),
        .carrier_on (carrier_on),
        .pop        (pop),
        .ir_out     (ir_out)
    );

    irtx_lowirq #(.CNT_W(CNT_W)) u_irq (
        .count         (fill_count),
        .thr_sel       (thr_sel),
        .lowirq_en     (lowirq_en),
        .irq_global_en (irq_global_en),
        .low_irq       (low_irq)
    );

endmodule

// File: rtl/irtx_checker.sv
module irtx_checker #(
    parameter int DEPTH = 32,
    parameter int CNT_W = 6
) (
    input logic             clk,
    input logic             rst,
    input logic             wr_en,
    input logic             fifo_clr,
    input logic             lowirq_en,
    input logic             irq_global_en,
    input logic             carrier_on,
    input logic             ir_out,
    input logic [CNT_W-1:0] fill_count,
    input logic             overflow,
    input logic             low_irq
);
    AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (rst)
        int'(fill_count) <= DEPTH);                                          // R1

    AST_FULL_NO_WRAP: assert property (@(posedge clk) disable iff (rst)
        (int'(fill_count) == DEPTH && !fifo_clr) |=> int'(fill_count) >= DEPTH - 1); // R1

    AST_MARK_GATED: assert property (@(posedge clk) disable iff (rst)
        ir_out |-> carrier_on);                                              // R2

    AST_OVF_SET: assert property (@(posedge clk) disable iff (rst)
        (wr_en && int'(fill_count) == DEPTH && !fifo_clr) |=> overflow);     // R6

    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
        (overflow && !fifo_clr) |=> overflow);                               // R6

    AST_CLR_EMPTY: assert property (@(posedge clk) disable iff (rst)
        fifo_clr |=> (fill_count == '0 && !overflow && !ir_out));            // R7

    AST_IRQ_GATE: assert property (@(posedge clk) disable iff (rst)
        low_irq |-> (lowirq_en && irq_global_en));                           // R9
endmodule

bind irtx_runlength irtx_checker #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .wr_en         (wr_en),
    .fifo_clr      (fifo_clr),
    .lowirq_en     (lowirq_en),
    .irq_global_en (irq_global_en),
    .carrier_on    (carrier_on),
    .ir_out        (ir_out),
    .fill_count    (fill_count),
    .overflow      (overflow),
    .low_irq       (low_irq)
);

// File: tb/irtx_runlength_test.sv
module irtx_runlength_test;
    localparam int DEPTH       = 32;
    localparam int SAMPLE_CLKS = 4;
    localparam int DIV_W       = 8;
    localparam int CNT_W       = $clog2(DEPTH + 1);

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             wr_en = 1'b0;
    logic [7:0]       wr_data = '0;
    logic             fifo_clr = 1'b0;
    logic [1:0]       thr_sel = 2'd2;
    logic             lowirq_en = 1'b1;
    logic             irq_global_en = 1'b1;
    logic [DIV_W-1:0] baud_div = 8'd1;
    logic             carrier_on = 1'b1;
    logic             ir_out;
    logic [CNT_W-1:0] fill_count;
    logic             overflow;
    logic             low_irq;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done   = 0;

    irtx_runlength #(.DEPTH(DEPTH), .SAMPLE_CLKS(SAMPLE_CLKS), .DIV_W(DIV_W)) uut (
        .clk (clk), .rst (rst), .wr_en (wr_en), .wr_data (wr_data),
        .fifo_clr (fifo_clr), .thr_sel (thr_sel), .lowirq_en (lowirq_en),
        .irq_global_en (irq_global_en), .baud_div (baud_div),
        .carrier_on (carrier_on), .ir_out (ir_out), .fill_count (fill_count),
        .overflow (overflow), .low_irq (low_irq)
    );

    always #2 clk = ~clk;   // 250 MHz

    // ---------------- reference model ----------------
    logic [7:0] mq[$];
    bit         m_play, m_space, m_ovf;
    int         m_left;

    function automatic int level_of(input logic [1:0] s);
        case (s)
            2'd0: return 1;
            2'd1: return 7;
            2'd2: return 17;
            default: return 25;
        endcase
    endfunction

    function automatic int sym_cycles(input logic [7:0] b, input int div);
        int len = (b[6:0] == 0) ? 128 : int'(b[6:0]);
        return len * SAMPLE_CLKS * ((div == 0) ? 1 : div);
    endfunction

    always @(posedge clk) begin
        int pre;
        bit fin;
        logic [7:0] b;
        if (rst) begin
            mq.delete(); m_play = 0; m_space = 1; m_ovf = 0; m_left = 0;
        end else if (fifo_clr) begin
            mq.delete(); m_play = 0; m_ovf = 0;
        end else begin
            pre = mq.size();
            fin = m_play && (m_left == 1);
            if ((!m_play || fin) && pre > 0) begin
                b = mq.pop_front();
                m_play = 1; m_space = b[7];
                m_left = sym_cycles(b, int'(baud_div));
            end else if (fin) begin
                m_play = 0;
            end else if (m_play) begin
                m_left--;
            end
            if (wr_en) begin
                if (pre == DEPTH) m_ovf = 1;
                else mq.push_back(wr_data);
            end
        end
        cycles++;
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cycles);
        end
    endtask

    // cycle-exact comparison away from the active edge
    always @(negedge clk) begin
        if (!rst && !done) begin
            chk("R2 R3 R4 R5 ir_out", int'(ir_out),
                int'(m_play && !m_space && carrier_on));
            chk("R1 fill_count", int'(fill_count), mq.size());
            chk("R6 overflow", int'(overflow), int'(m_ovf));
            chk("R8 R9 low_irq", int'(low_irq),
                int'(lowirq_en && irq_global_en && (mq.size() <= level_of(thr_sel))));
        end
    end

    task automatic step();
        @(posedge clk); #1;
    endtask

    task automatic put(input logic [7:0] d);
        wr_en = 1'b1; wr_data = d; step(); wr_en = 1'b0;
    endtask

    task automatic clear_all();
        fifo_clr = 1'b1; step(); fifo_clr = 1'b0;
    endtask

    // length of the next mark, in cycles, with the carrier held on
    task automatic measure_mark(output int n);
        n = 0;
        while (ir_out !== 1'b1) @(negedge clk);
        while (ir_out === 1'b1) begin n++; @(negedge clk); end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        int n;
        void'($urandom(32'h1F2E3D4C));
        repeat (3) step();
        @(negedge clk);
        chk("R1 reset fill", int'(fill_count), 0);
        chk("R5 reset ir_out", int'(ir_out), 0);
        chk("R6 reset overflow", int'(overflow), 0);
        chk("R9 reset low_irq", int'(low_irq), 1);
        step();
        rst = 1'b0;
        step();

        // R4: zero run length lasts 128 periods
        put(8'h00);
        measure_mark(n);
        chk("R4 zero-length mark cycles", n, 128 * SAMPLE_CLKS);

        // R3: run 5 at divisor 3, then divisor 0 acts as 1
        step(); baud_div = 8'd3;
        put(8'h05);
        measure_mark(n);
        chk("R3 mark cycles div3", n, 5 * SAMPLE_CLKS * 3);
        step(); baud_div = 8'd0;
        put(8'h09);
        measure_mark(n);
        chk("R3 mark cycles div0", n, 9 * SAMPLE_CLKS);
        baud_div = 8'd1;

        // R5: space then mark back to back; R3 late write does not shorten
        put(8'h83); put(8'h02);
        measure_mark(n);
        chk("R5 mark after space", n, 2 * SAMPLE_CLKS);

        // R6: overfill with long spaces, sweep thresholds (R8)
        clear_all();
        for (int i = 0; i < 40; i++) put(8'hFF);
        @(negedge clk);
        chk("R6 overflow after overfill", int'(overflow), 1);
        chk("R1 full count", int'(fill_count), 32);
        for (int s = 0; s < 4; s++) begin thr_sel = 2'(s); repeat (2) step(); end
        // R7: clear with a simultaneous write
        fifo_clr = 1'b1; wr_en = 1'b1; wr_data = 8'h11; step();
        fifo_clr = 1'b0; wr_en = 1'b0;
        @(negedge clk);
        chk("R7 fill after clear", int'(fill_count), 0);
        chk("R7 overflow after clear", int'(overflow), 0);
        chk("R7 line idle after clear", int'(ir_out), 0);
        // R8: drain across thresholds with short symbols
        for (int s = 0; s < 4; s++) begin
            thr_sel = 2'(s);
            for (int i = 0; i < 30; i++) put(8'h01);
            repeat (200) step();
        end

        // constrained random phases
        for (int ph = 0; ph < 6; ph++) begin
            int wprob = (ph % 2 == 0) ? 35 : 6;
            clear_all();
            baud_div = DIV_W'(ph % 3);
            for (int c = 0; c < 5000; c++) begin
                logic [7:0] d;
                d[7]   = 1'($urandom);
                d[6:0] = ($urandom % 40 == 0) ? 7'($urandom) : 7'($urandom % 8);
                wr_en      = (($urandom % 100) < wprob);
                wr_data    = d;
                carrier_on = (($urandom % 4) != 0);
                if ($urandom % 64 == 0) thr_sel = 2'($urandom);
                if ($urandom % 128 == 0) lowirq_en = 1'($urandom);
                if ($urandom % 128 == 0) irq_global_en = 1'($urandom);
                fifo_clr   = ($urandom % 700 == 0);
                step();
            end
            wr_en = 1'b0; fifo_clr = 1'b0;
        end
        carrier_on = 1'b1;
        repeat (4) step();
        finish_run();
    end
endmodule